// File: doc/BRIEF.md
# Serial Register Slave with Indexed and Block Access

This block is a two-wire serial slave, compatible with the SMBus byte and block protocols, in front of a small bank of 8-bit control registers. A bus master can write or read one register picked by an offset, or stream a run of registers starting at the lowest one. Every register is also driven out in parallel, so the logic around it sees its settings without touching the bus. The bank comes out of reset holding fixed default values, so using the bus at all is optional.

Both bus lines are sampled by the system clock through synchroniser flops. Start, repeated start and stop are recognised from SDA edges while SCL is high. The slave pulls SDA low through an open-drain enable to acknowledge or to send a zero. It never stretches the clock. A power-down input makes the slave release the bus and ignore all traffic.

After the device address, the master sends a command byte. Its top bit chooses single-register access (1) or block access (0). Bits 6:5 must be zero for the device to answer. Bits 4:0 give the offset for single-register access. Block transfers carry a byte count ahead of the data in both directions.

Top module: `smb_regbank`

## Requirements
- R1: After reset, the bank holds register 0 = 0xFF, register 1 = 0xFF, register 2 = 0xEB, register 3 = 0xAF and register 4 = 0x02. Register k appears on reg_q[8k+7:8k].
- R2: The slave acknowledges only the address byte 0xD2 (7-bit address 0x69 with write bit 0) or 0xD3 (read bit 1). An acknowledge is SDA low during the ninth clock. Any other address is not acknowledged, and the rest of that transfer up to the next start changes nothing.
- R3: A command byte whose bits 6:5 are not 00 is not acknowledged, and data that follows it in the same transfer is discarded.
- R4: A byte write (command bit 7 = 1, offset in bits 4:0, then one data byte) stores the data into the register at that offset. An offset of 5 or above is acknowledged but changes no register. A second data byte is not acknowledged.
- R5: A byte read (command with bit 7 = 1, repeated start, address 0xD3) returns the register at the offset, MSB first, with SDA changing only while SCL is low. Offsets of 5 or above return 0x00.
- R6: A block write (command 0x00, then a count byte, then data) fills registers from 0 upward. Every byte up to the count is acknowledged, and data bytes beyond the count are not acknowledged and are dropped.
- R7: A block read (command 0x00, repeated start, address 0xD3) returns 0x05 first, then registers 0 upward, then 0x00 for each further byte the master acknowledges. A master NOT-acknowledge ends the transfer.
- R8: A stop after any complete byte ends the transfer. Bytes already written stay, later registers keep their values, and the next start is served normally.
- R9: While pwr_dn is high the slave never pulls SDA low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset, loads defaults |
| pwr_dn | input | 1 | Power-down: bus released, traffic ignored |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (open drain) |
| reg_q | output | 40 | All registers side by side, register k at bits 8k+7:8k |

## Verification
Single-register reads sweep all 32 offsets. This separates the implemented registers from the zero-returning holes and shows that the offset field is decoded in full. Writes sweep offsets across the bank edge with data patterns that differ per offset, so a wrong write address shows up as a wrong register on the parallel output. Block writes run with a count equal to, below and cut short of the bank size, which separates count-limited acknowledges from stop-aborted transfers. Foreign addresses, non-zero chip-select values and power-down each get followed by data bytes, so a leak would change a register that the bench reads afterwards.

// File: rtl/smb_pkg.sv
package smb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } smb_state_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_CMD,
      PH_COUNT,
      PH_DATA
   } smb_phase_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smb_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_p  <= scl_ff[STAGES-1];
         sda_p  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s    = scl_ff[STAGES-1];
   assign sda_s    = sda_ff[STAGES-1];
   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
   parameter int NREG = 5,
   parameter int DW   = 8,
   parameter int AW   = 8,
   parameter logic [NREG*DW-1:0] DEFAULTS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DW-1:0]     rdata,
   output logic [NREG*DW-1:0] q
);
   if (NREG < 1 || NREG >= (1 << AW)) begin : g_bad_depth
      $error("smb_regfile: NREG out of range for AW");
   end

   logic [DW-1:0] mem [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= DEFAULTS[i*DW +: DW];
         else if (we && waddr == AW'(i))
            mem[i] <= wdata;
      end
      assign q[i*DW +: DW] = mem[i];
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NREG; k++)
         if (raddr == AW'(k)) rdata = mem[k];
   end

   // R9
   hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
   parameter int NREG = 5,
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int SYNC_STAGES = 2,
   parameter logic [NREG*8-1:0] DEFAULTS = 40'h02_AF_EB_FF_FF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pwr_dn,
   input  logic            scl_i,
   input  logic            sda_i,
   output logic            sda_oe,
   output logic [NREG*8-1:0] reg_q
);
   import smb_pkg::*;

   localparam int PW = 8;
   localparam logic [PW-1:0] NREG_B = PW'(NREG);
   localparam logic [7:0] COUNT_BYTE = 8'(NREG);

   if (NREG < 1 || NREG > 32) begin : g_bad_nreg
      $error("smb_regbank: NREG must be 1..32");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

   smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   smb_state_e    state;
   smb_phase_e    phase;
   logic [3:0]    bitcnt;
   logic [7:0]    shreg;
   logic          blk, go_tx, mack;
   logic [PW-1:0] ptr, ptr_nx;
   logic [7:0]    remaining;
   logic [7:0]    rdata;
   logic          we, byte_done;

   assign byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
   assign we = byte_done && !pwr_dn && (phase == PH_DATA) &&
               (remaining != 8'd0) && (ptr < NREG_B);
   assign ptr_nx = (ptr == '1) ? ptr : ptr + PW'(1);

   smb_regfile #(.NREG(NREG), .DW(8), .AW(PW), .DEFAULTS(DEFAULTS)) regs_i (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr), .wdata(shreg),
      .raddr(ptr), .rdata(rdata), .q(reg_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         phase     <= PH_ADDR;
         bitcnt    <= '0;
         shreg     <= '0;
         blk       <= 1'b0;
         go_tx     <= 1'b0;
         mack      <= 1'b0;
         ptr       <= '0;
         remaining <= '0;
         sda_oe    <= 1'b0;
      end else if (pwr_dn || stop_ev) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (start_ev) begin
         state  <= ST_RX;
         phase  <= PH_ADDR;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_RX: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  bitcnt <= '0;
                  state  <= ST_IDLE;
                  unique case (phase)
                     PH_ADDR: if (shreg[7:1] == DEV_ADDR) begin
                        state  <= ST_RX_ACK;
                        sda_oe <= 1'b1;
                        go_tx  <= shreg[0];
                        if (!shreg[0]) phase <= PH_CMD;
                     end
                     PH_CMD: if (shreg[6:5] == 2'b00) begin
                        state     <= ST_RX_ACK;
                        sda_oe    <= 1'b1;
                        blk       <= ~shreg[7];
                        ptr       <= shreg[7] ? PW'(shreg[4:0]) : '0;
                        phase     <= shreg[7] ? PH_DATA : PH_COUNT;
                        remaining <= 8'd1;
                     end
                     PH_COUNT: begin
                        state     <= ST_RX_ACK;
                        sda_oe    <= 1'b1;
                        remaining <= shreg;
                        phase     <= PH_DATA;
                     end
                     default: if (remaining != 8'd0) begin
                        state     <= ST_RX_ACK;
                        sda_oe    <= 1'b1;
                        remaining <= remaining - 8'd1;
                        ptr       <= ptr_nx;
                     end
                  endcase
               end
            end
            ST_RX_ACK: if (scl_fall) begin
               bitcnt <= '0;
               go_tx  <= 1'b0;
               if (go_tx) begin
                  state <= ST_TX;
                  if (blk) begin
                     shreg  <= COUNT_BYTE;
                     sda_oe <= ~COUNT_BYTE[7];
                  end else begin
                     shreg  <= rdata;
                     sda_oe <= ~rdata[7];
                     ptr    <= ptr_nx;
                  end
               end else begin
                  state  <= ST_RX;
                  sda_oe <= 1'b0;
               end
            end
            ST_TX: if (scl_fall) begin
               if (bitcnt == 4'd7) begin
                  state  <= ST_TX_ACK;
                  sda_oe <= 1'b0;
               end else begin
                  shreg  <= {shreg[6:0], 1'b0};
                  sda_oe <= ~shreg[6];
                  bitcnt <= bitcnt + 4'd1;
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) mack <= ~sda_s;
               else if (scl_fall) begin
                  if (mack) begin
                     state  <= ST_TX;
                     bitcnt <= '0;
                     shreg  <= rdata;
                     sda_oe <= ~rdata[7];
                     ptr    <= ptr_nx;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R8
   stop_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_ev && !pwr_dn) |=> (state == ST_IDLE && !sda_oe));

   // R9
   pdn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> !sda_oe);

   // R5
   sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_dn && !$past(pwr_dn) && !$past(start_ev) && !$past(stop_ev) &&
       (sda_oe != $past(sda_oe))) |-> !$past(scl_s));

   // R2
   start_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev && !pwr_dn) |=> (state == ST_RX && bitcnt == 4'd0));
endmodule

// File: tb/smb_regbank_tb.sv
module smb_regbank_tb_top;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_dn = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic [39:0] reg_q;
   wire  sda_bus = sda_m & ~sda_oe;

   int nchk = 0;
   int nfail = 0;
   logic [7:0] m [5];

   always #4 clk = ~clk;

   smb_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .scl_i(scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .reg_q(reg_q)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_bank(input string tag);
      for (int k = 0; k < 5; k++)
         chk(reg_q[k*8 +: 8] == m[k], tag, reg_q[k*8 +: 8], m[k]);
   endtask

   task automatic wq();
      repeat (Q) @(posedge clk);
      #2;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl = 1'b1; wq();
      ack = !sda_bus;
      wq(); scl = 1'b0; wq();
   endtask

   task automatic recv(output logic [7:0] b, input bit mack);
      sda_m = 1'b1;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         wq(); scl = 1'b1; wq();
         b = {b[6:0], sda_bus};
         wq(); scl = 1'b0;
      end
      sda_m = !mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
      sda_m = 1'b1;
   endtask

   task automatic byte_write(input logic [4:0] off, input logic [7:0] d, output bit a1, output bit a2, output bit a3);
      bus_start(); send(8'hD2, a1); send({3'b100, off}, a2); send(d, a3); bus_stop();
   endtask

   task automatic byte_read(input logic [4:0] off, output logic [7:0] d, output bit ok);
      bit a1, a2, a3;
      bus_start(); send(8'hD2, a1); send({3'b100, off}, a2);
      bus_rstart(); send(8'hD3, a3); recv(d, 1'b0); bus_stop();
      ok = a1 & a2 & a3;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      bit a1, a2, a3, ok;
      logic [7:0] d, e;
      m[0] = 8'hFF; m[1] = 8'hFF; m[2] = 8'hEB; m[3] = 8'hAF; m[4] = 8'h02;
      repeat (4) @(posedge clk); #2;
      rst_n = 1'b1;
      wq();
      // R1: reset defaults on the parallel outputs
      chk_bank("R1 defaults");
      chk(sda_oe == 1'b0, "R1 bus released", sda_oe, 0);

      // R5: byte read sweep over all offsets
      for (int off = 0; off < 32; off++) begin
         byte_read(5'(off), d, ok);
         e = (off < 5) ? m[off] : 8'h00;
         chk(ok, "R5 read acks", ok, 1);
         chk(d == e, "R5 byte read data", d, e);
      end

      // R4: byte write sweep across the bank edge
      for (int off = 0; off < 8; off++) begin
         e = 8'h3C ^ 8'(off * 8'h11);
         byte_write(5'(off), e, a1, a2, a3);
         chk(a1 && a2 && a3, "R4 write acks", {a1, a2, a3}, 3'b111);
         if (off < 5) m[off] = e;
         chk_bank("R4 byte write");
      end
      for (int off = 0; off < 5; off++) begin
         byte_read(5'(off), d, ok);
         chk(d == m[off], "R5 read back", d, m[off]);
      end

      // R4: second data byte in a byte write is refused
      bus_start(); send(8'hD2, a1); send(8'h81, a2); send(8'h11, a3);
      m[1] = 8'h11;
      send(8'h22, a1); bus_stop();
      chk(!a1, "R4 extra byte nack", a1, 0);
      chk_bank("R4 extra byte dropped");

      // R2: foreign addresses
      foreach (m[k]) ;
      for (int i = 0; i < 4; i++) begin
         d = (i == 0) ? 8'hD0 : (i == 1) ? 8'hD6 : (i == 2) ? 8'h52 : 8'hD4;
         bus_start(); send(d, a1); send(8'h80, a2); send(8'h5A, a3); bus_stop();
         chk(!a1, "R2 foreign address nack", a1, 0);
         chk_bank("R2 foreign address ignored");
      end

      // R3: chip-select field must be zero
      for (int cs = 1; cs < 4; cs++) begin
         bus_start(); send(8'hD2, a1); send({1'b1, 2'(cs), 5'd2}, a2); send(8'h77, a3); bus_stop();
         chk(a1 && !a2, "R3 chip select nack", {a1, a2}, 2'b10);
         chk_bank("R3 chip select ignored");
      end

      // R6: block write with full count
      bus_start(); send(8'hD2, a1); send(8'h00, a2); send(8'd5, a3);
      chk(a1 && a2 && a3, "R6 header acks", {a1, a2, a3}, 3'b111);
      for (int k = 0; k < 5; k++) begin
         send(8'hA0 + 8'(k * 3), a1);
         m[k] = 8'hA0 + 8'(k * 3);
         chk(a1, "R6 data ack", a1, 1);
      end
      bus_stop();
      chk_bank("R6 block write full");

      // R6: count of 2 with 4 data bytes
      bus_start(); send(8'hD2, a1); send(8'h00, a2); send(8'd2, a3);
      for (int k = 0; k < 4; k++) begin
         send(8'h50 + 8'(k), a1);
         if (k < 2) m[k] = 8'h50 + 8'(k);
         chk(a1 == (k < 2), "R6 count limit ack", a1, (k < 2));
      end
      bus_stop();
      chk_bank("R6 block write short count");

      // R7: block read past the end
      bus_start(); send(8'hD2, a1); send(8'h00, a2); bus_rstart(); send(8'hD3, a3);
      chk(a1 && a2 && a3, "R7 header acks", {a1, a2, a3}, 3'b111);
      recv(d, 1'b1);
      chk(d == 8'h05, "R7 count byte", d, 8'h05);
      for (int k = 0; k < 7; k++) begin
         recv(d, k != 6);
         e = (k < 5) ? m[k] : 8'h00;
         chk(d == e, "R7 block read data", d, e);
      end
      bus_stop();
      chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);

      // R8: stop after two data bytes of a five-byte block write
      bus_start(); send(8'hD2, a1); send(8'h00, a2); send(8'd5, a3);
      send(8'hC1, a1); send(8'hC2, a2); bus_stop();
      m[0] = 8'hC1; m[1] = 8'hC2;
      chk_bank("R8 stop aborts block write");
      byte_read(5'd1, d, ok);
      chk(ok && d == 8'hC2, "R8 next transfer served", d, 8'hC2);
      // R8: stop right after the command byte
      bus_start(); send(8'hD2, a1); send(8'h83, a2); bus_stop();
      chk_bank("R8 stop after command");

      // R9: power-down
      pwr_dn = 1'b1; wq();
      byte_write(5'd0, 8'h00, a1, a2, a3);
      chk(!a1, "R9 no ack in power-down", a1, 0);
      chk_bank("R9 registers frozen");
      pwr_dn = 1'b0; wq();
      byte_read(5'd0, d, ok);
      chk(ok && d == m[0], "R9 resumes after power-down", d, m[0]);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule